// File: doc/BRIEF.md
# Johnson Decade Counter with Seven-Segment Decoder

This block counts events from zero to nine and shows the current digit on a
common-cathode seven-segment display. The count is held in a five-stage
twisted-ring (Johnson) register with ten legal codes. Any other code is steered
back into the ring on the next count event. A decoder turns the ring code into
seven active-high segment lines. A blanking input can turn all seven off. A
second copy of the c segment ignores blanking. A carry line drives the count
input of the next decade in a chain.

The count input and the inhibit input are asynchronous to the system clock
`clk`. Each one passes through its own synchronizer chain. A count event is a
rising edge of (count clock AND NOT inhibit), seen on the synchronized copies.
This gives two ways to count. One is rising edges of the count clock while
inhibit is low. The other is falling edges of inhibit while the count clock is
held high. The count reset is sampled on `clk` and overrides counting. All pins
are plain control levels, so there is no stream handshake and no back-pressure
at the edge of the block.

Top module: `decade_johnson_display`

## Requirements
- R1: The ring register holds only the ten codes 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000, which stand for digits 0 through 9. A count event in any of the other 22 codes loads 00000.
- R2: While `cnt_reset` is high on a `clk` edge, the count goes to 0. A count event that arrives during reset is discarded.
- R3: A rising edge on `cnt_clk` while `cnt_hold` is low advances the digit by one, and 9 wraps to 0.
- R4: While `cnt_hold` is high, edges on `cnt_clk` leave the digit unchanged.
- R5: With `cnt_clk` held high, a falling edge on `cnt_hold` advances the digit by one.
- R6: `carry_o` is high for digits 0 to 4 and low for digits 5 to 9. Its rising edge therefore marks the wrap from 9 to 0.
- R7: `seg_o` is active high, with bit 0 = a, bit 1 = b, bit 2 = c, bit 3 = d, bit 4 = e, bit 5 = f and bit 6 = g. Digits 0 to 9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).
- R8: When `disp_en_i` is low, all seven bits of `seg_o` are 0. `disp_en_o` equals `disp_en_i` in the same cycle.
- R9: `seg_c_raw_o` shows the decoded c segment whatever the level of `disp_en_i`.
- R10: A change on a count pin takes effect on the digit at the third rising `clk` edge after it is set up, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| cnt_reset | input | 1 | Synchronous count reset, active high |
| cnt_clk | input | 1 | Asynchronous count clock |
| cnt_hold | input | 1 | Asynchronous inhibit; can also act as a falling-edge count input |
| disp_en_i | input | 1 | Display enable, high lights the segments |
| seg_o | output | 7 | Gated segments, bit 0 = a through bit 6 = g |
| seg_c_raw_o | output | 1 | c segment without blanking |
| carry_o | output | 1 | Decade carry, high for digits 0 to 4 |
| disp_en_o | output | 1 | Same-cycle copy of disp_en_i |

## Verification
The digit, and with it the segments, the carry and the ungated c line, changes at the third rising `clk` edge after a count pin changes. That edge comes after two synchronizer stages and the edge detector. The enable pass-through and the blanking are combinational and apply in the same cycle. The bench changes pins on falling edges and samples four falling edges later, so every result has settled. One directed case samples after two rising edges and again after three, to pin down that latency exactly.

// File: rtl/jdc_pkg.sv
package jdc_pkg;
  localparam int JSTAGES = 5;
  localparam int SEGS    = 7;
  typedef logic [JSTAGES-1:0] jstate_t;
  typedef logic [SEGS-1:0]    seg_t;

  // A legal twisted-ring code has at most one bit-to-bit change along the word.
  function automatic logic jvalid(input jstate_t s);
    int changes;
    changes = 0;
    for (int i = 0; i < JSTAGES-1; i++)
      if (s[i] != s[i+1]) changes++;
    return (changes <= 1);
  endfunction
endpackage

// File: rtl/jdc_sync.sv
module jdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) sh <= d;
    end else begin : g_many
      always_ff @(posedge clk) sh <= {sh[STAGES-2:0], d};
    end
  endgenerate
  assign q = sh[STAGES-1];
endmodule

// File: rtl/jdc_event.sv
module jdc_event #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic cnt_clk,
  input  logic cnt_hold,
  output logic step_o
);
  logic clk_s, hold_s, gated, prev_q;

  jdc_sync #(.STAGES(SYNC_STAGES)) u_sync_clk  (.clk(clk), .d(cnt_clk),  .q(clk_s));
  jdc_sync #(.STAGES(SYNC_STAGES)) u_sync_hold (.clk(clk), .d(cnt_hold), .q(hold_s));

  assign gated = clk_s & ~hold_s;

  always_ff @(posedge clk) prev_q <= gated;

  assign step_o = gated & ~prev_q;
endmodule

// File: rtl/jdc_ring.sv
module jdc_ring
  import jdc_pkg::*;
(
  input  logic    clk,
  input  logic    reset,
  input  logic    step,
  output jstate_t state_o
);
  jstate_t state_q, next_s;

  always_comb begin
    if (!jvalid(state_q)) next_s = '0;
    else                  next_s = {state_q[JSTAGES-2:0], ~state_q[JSTAGES-1]};
  end

  always_ff @(posedge clk) begin
    if (reset)     state_q <= '0;
    else if (step) state_q <= next_s;
  end

  assign state_o = state_q;
endmodule

// File: rtl/jdc_decode.sv
module jdc_decode
  import jdc_pkg::*;
(
  input  jstate_t state_i,
  output seg_t    seg_o,
  output logic    carry_o
);
  logic [3:0] ones, digit;

  always_comb begin
    ones = '0;
    for (int i = 0; i < JSTAGES; i++) ones = ones + {3'b0, state_i[i]};
    digit = state_i[JSTAGES-1] ? (4'd10 - ones) : ones;
  end

  always_comb begin
    unique case (digit)
      4'd0:    seg_o = 7'h3F;
      4'd1:    seg_o = 7'h06;
      4'd2:    seg_o = 7'h5B;
      4'd3:    seg_o = 7'h4F;
      4'd4:    seg_o = 7'h66;
      4'd5:    seg_o = 7'h6D;
      4'd6:    seg_o = 7'h7D;
      4'd7:    seg_o = 7'h07;
      4'd8:    seg_o = 7'h7F;
      4'd9:    seg_o = 7'h6F;
      default: seg_o = 7'h00;
    endcase
  end

  assign carry_o = ~state_i[JSTAGES-1];
endmodule

// File: rtl/decade_johnson_display.sv
module decade_johnson_display
  import jdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       cnt_reset,
  input  logic       cnt_clk,
  input  logic       cnt_hold,
  input  logic       disp_en_i,
  output logic [6:0] seg_o,
  output logic       seg_c_raw_o,
  output logic       carry_o,
  output logic       disp_en_o
);
  logic    step;
  jstate_t state;
  seg_t    seg_raw;

  jdc_event #(.SYNC_STAGES(SYNC_STAGES)) u_event (
    .clk(clk), .cnt_clk(cnt_clk), .cnt_hold(cnt_hold), .step_o(step)
  );

  jdc_ring u_ring (.clk(clk), .reset(cnt_reset), .step(step), .state_o(state));

  jdc_decode u_dec (.state_i(state), .seg_o(seg_raw), .carry_o(carry_o));

  assign seg_o       = disp_en_i ? seg_raw : '0;
  assign seg_c_raw_o = seg_raw[2];
  assign disp_en_o   = disp_en_i;
endmodule

// File: rtl/jdc_checker.sv
module jdc_checker
  import jdc_pkg::*;
(
  input logic       clk,
  input logic       reset,
  input logic       step,
  input jstate_t    state,
  input logic [6:0] seg_o,
  input logic       seg_c_raw_o,
  input logic       carry_o,
  input logic       disp_en_i
);
  logic legal;
  always_comb legal = jvalid(state);

  assert_ring_legal_R1: assert property (@(posedge clk) disable iff (reset)
    step |=> jvalid(state));
  assert_antilock_R1: assert property (@(posedge clk) disable iff (reset)
    (step && !legal) |=> state == '0);
  assert_reset_zero_R2: assert property (@(posedge clk)
    reset |=> state == '0);
  assert_step_shift_R3: assert property (@(posedge clk) disable iff (reset)
    (step && legal) |=> state == {$past(state[JSTAGES-2:0]), ~$past(state[JSTAGES-1])});
  assert_hold_R4: assert property (@(posedge clk) disable iff (reset)
    !step |=> $stable(state));
  assert_carry_wrap_R6: assert property (@(posedge clk) disable iff (reset)
    $rose(carry_o) |-> (state == '0 && $past(state) == 5'b10000));
  assert_blank_R8: assert property (@(posedge clk) disable iff (reset)
    !disp_en_i |-> seg_o == '0);
  assert_c_raw_R9: assert property (@(posedge clk) disable iff (reset)
    disp_en_i |-> seg_o[2] == seg_c_raw_o);
endmodule

bind decade_johnson_display jdc_checker u_chk (
  .clk(clk), .reset(cnt_reset), .step(step), .state(state),
  .seg_o(seg_o), .seg_c_raw_o(seg_c_raw_o), .carry_o(carry_o), .disp_en_i(disp_en_i)
);

// File: tb/tb_decade_johnson_display.sv
module tb_decade_johnson_display;
  logic clk = 1'b0;
  logic cnt_reset, cnt_clk, cnt_hold, disp_en_i;
  logic [6:0] seg_o;
  logic seg_c_raw_o, carry_o, disp_en_o;

  int checks = 0;
  int errors = 0;
  int digit  = 0;
  logic mgated = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  decade_johnson_display dut (
    .clk(clk), .cnt_reset(cnt_reset), .cnt_clk(cnt_clk), .cnt_hold(cnt_hold),
    .disp_en_i(disp_en_i), .seg_o(seg_o), .seg_c_raw_o(seg_c_raw_o),
    .carry_o(carry_o), .disp_en_o(disp_en_o)
  );

  function automatic logic [6:0] seg_of(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; default: return 7'h6F;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Update the model after pins settle, then compare all outputs.
  task automatic settle_and_check(input string req);
    logic g;
    ticks(4);
    g = cnt_clk & ~cnt_hold;
    if (!cnt_reset && g && !mgated) digit = (digit + 1) % 10;
    mgated = g;
    chk({req, " seg R7 R8"}, {1'b0, seg_o}, {1'b0, disp_en_i ? seg_of(digit) : 7'h00});
    chk("R9 c raw", {7'b0, seg_c_raw_o}, {7'b0, seg_of(digit)[2]});
    chk("R6 carry", {7'b0, carry_o}, {7'b0, (digit < 5)});
    chk("R8 enable out", {7'b0, disp_en_o}, {7'b0, disp_en_i});
  endtask

  task automatic show_all(output logic [6:0] s);
    logic e;
    e = disp_en_i;
    disp_en_i = 1'b1;
    #0.1;
    s = seg_o;
    disp_en_i = e;
  endtask

  initial begin
    logic [6:0] s;
    logic legal;
    cnt_reset = 1'b1; cnt_clk = 1'b0; cnt_hold = 1'b0; disp_en_i = 1'b1;
    ticks(5);
    cnt_reset = 1'b0;
    digit = 0; mgated = 1'b0;
    ticks(1);
    chk("R2 reset digit 0", {1'b0, seg_o}, 8'h3F);
    chk("R6 carry after reset", {7'b0, carry_o}, 8'h01);

    // R10: latency of exactly three rising edges
    cnt_clk = 1'b1;
    ticks(2);
    chk("R10 not yet advanced", {1'b0, seg_o}, 8'h3F);
    ticks(1);
    chk("R10 advanced at third edge R3", {1'b0, seg_o}, 8'h06);
    digit = 1; mgated = 1'b1;
    cnt_clk = 1'b0; settle_and_check("R3");

    // R3 full ring with wrap; R6 carry edges
    for (int k = 0; k < 10; k++) begin
      cnt_clk = 1'b1; settle_and_check("R3 up");
      cnt_clk = 1'b0; settle_and_check("R3 down");
    end
    chk("R3 wrap back to 1", digit[7:0], 8'd1);

    // R4: inhibit blocks clock edges
    cnt_hold = 1'b1; settle_and_check("R4");
    for (int k = 0; k < 3; k++) begin
      cnt_clk = 1'b1; settle_and_check("R4 edge ignored");
      cnt_clk = 1'b0; settle_and_check("R4 edge ignored");
    end
    chk("R4 held digit 1", {1'b0, seg_o}, 8'h06);

    // R5: clock high, falling inhibit counts
    cnt_clk = 1'b1; settle_and_check("R5");
    cnt_hold = 1'b0; settle_and_check("R5 fall");
    chk("R5 digit 2", {1'b0, seg_o}, 8'h5B);
    cnt_hold = 1'b1; settle_and_check("R5 rise no count");
    cnt_hold = 1'b0; settle_and_check("R5 fall");
    chk("R5 digit 3", {1'b0, seg_o}, 8'h4F);

    // R8/R9: blanking
    disp_en_i = 1'b0; settle_and_check("R8 blank");
    chk("R8 all off", {1'b0, seg_o}, 8'h00);
    chk("R9 c raw while blank", {7'b0, seg_c_raw_o}, 8'h01);
    disp_en_i = 1'b1;

    // R2: edge during reset is discarded
    cnt_reset = 1'b1; cnt_clk = 1'b0; ticks(4);
    cnt_clk = 1'b1; ticks(4);
    digit = 0; mgated = 1'b1;
    cnt_reset = 1'b0; ticks(4);
    chk("R2 reset priority", {1'b0, seg_o}, 8'h3F);

    // Random mix
    for (int k = 0; k < 600; k++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 5)      cnt_clk   = ~cnt_clk;
      else if (op < 8) cnt_hold  = ~cnt_hold;
      else if (op < 9) disp_en_i = ~disp_en_i;
      else begin
        cnt_reset = 1'b1; ticks(3);
        digit = 0;
        mgated = cnt_clk & ~cnt_hold;
        cnt_reset = 1'b0;
      end
      settle_and_check("R3 R4 R5 random");
      show_all(s);
      legal = 1'b0;
      for (int d = 0; d < 10; d++) if (s == seg_of(d)) legal = 1'b1;
      chk("R1 legal digit", {7'b0, legal}, 8'h01);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process::self();
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = int'($urandom(32'd1234));
  end
endmodule